// File: doc/BRIEF.md
# Message-to-Level Interrupt Bridge

This block takes message-signalled interrupts, each a one-cycle strobe carrying a vector index. It records every message in a per-vector pending bit. The pending bits that are not masked are combined into one registered, active-high level line, which goes to a host interrupt controller. Software demultiplexes the line by reading the pending register. It acknowledges a vector by writing a one to that vector's bit, which clears the bit inside the bridge.

Masking serves only to quiet vectors during startup and shutdown, and it never loses a message. A message for a masked vector still sets its pending bit. When that vector is later unmasked, the level line rises. A strobe whose index is out of range sets no pending bit. It increments a saturating error counter instead.

Top module: `msi_level_bridge`

## Requirements
- R1: A strobe on `msgValid` with `msgVector` below 32 sets bit `msgVector` of the pending register at the clock edge that samples the strobe.
- R2: `irqOut` is registered. After each clock edge it equals the OR over all vectors of (pending and not masked), taken from the state held before that edge.
- R3: A read at `regAddr` 0 returns the pending register, with bit i standing for vector i.
- R4: A write at `regAddr` 0 clears every pending bit whose data bit is 1 and leaves bits written with 0 unchanged. `irqOut` falls only when no unmasked vector is still pending.
- R5: `regAddr` 1 holds the mask register, and a 1 bit masks that vector. A message for a masked vector is still latched. No pending bit clears except through an acknowledge.
- R6: Unmasking a vector whose pending bit is set raises `irqOut` one clock after the mask write takes effect.
- R7: When an acknowledge and a new message for the same vector arrive in the same cycle, that pending bit ends up set.
- R8: A strobe with `msgVector` of 32 or more changes no pending bit and increments an 8-bit error counter. The counter reads in bits 7:0 at `regAddr` 2 and saturates at 255.
- R9: After reset the pending register is 0, the mask register is all ones, the error counter is 0 and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | One-cycle message strobe |
| msgVector | input | 6 | Vector index carried by the message |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 pending, 1 mask, 2 error count) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Registered level interrupt to the host controller |

## Verification
The bench sends messages while vectors are masked and then unmasks them. A bridge that dropped messages under mask, or that did not re-raise the line on unmask, would leave `irqOut` low. It also lands an acknowledge and a message for the same vector on one edge; a design where the clear wins would lose that interrupt. It then acknowledges one of two unmasked pending vectors, to catch a line that falls too early, and checks the cycle in which the registered line moves. Out-of-range indices are driven until the error counter saturates, which exposes a counter that wraps or an index that aliases onto a real vector.

// File: rtl/msi_bridge_pkg.sv
package msi_bridge_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PEND = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_ERR  = 2'd2;

  typedef struct packed {
    logic msgHit;   // valid message, in-range vector
    logic msgErr;   // valid message, out-of-range vector
    logic ackWr;    // write-one-to-clear on pending
    logic maskWr;   // load mask register
  } ctrlStrobes_t;
endpackage

// File: rtl/msi_bridge_ctrl.sv
module msi_bridge_ctrl
  import msi_bridge_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int IDX_W   = 6
) (
  input  logic                  msgValid,
  input  logic [IDX_W-1:0]      msgVector,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output ctrlStrobes_t          strb
);
  logic inRange;

  always_comb begin
    inRange     = int'(msgVector) < NUM_VEC;
    strb.msgHit = msgValid && inRange;
    strb.msgErr = msgValid && !inRange;
    strb.ackWr  = regWrEn && (regAddr == ADDR_PEND);
    strb.maskWr = regWrEn && (regAddr == ADDR_MASK);
  end
endmodule

// File: rtl/msi_bridge_dp.sv
module msi_bridge_dp
  import msi_bridge_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int IDX_W   = 6,
  parameter int ERR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic [IDX_W-1:0]      msgVector,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_VEC-1:0]    regWrData,
  output logic [NUM_VEC-1:0]    regRdData,
  output logic [NUM_VEC-1:0]    pendingQ,
  output logic [NUM_VEC-1:0]    maskQ,
  output logic [ERR_W-1:0]      errCnt,
  output logic                  irqOut
);
  localparam int PAD_W = NUM_VEC - ERR_W;

  logic [NUM_VEC-1:0] setVec;
  logic [NUM_VEC-1:0] clrVec;
  logic [NUM_VEC-1:0] pendingNext;

  always_comb begin
    setVec      = strb.msgHit ? (NUM_VEC'(1) << msgVector) : '0;
    clrVec      = strb.ackWr ? regWrData : '0;
    // a new message beats a same-cycle acknowledge
    pendingNext = (pendingQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= '0;
      maskQ    <= '1;
      errCnt   <= '0;
      irqOut   <= 1'b0;
    end else begin
      pendingQ <= pendingNext;
      if (strb.maskWr) maskQ <= regWrData;
      if (strb.msgErr && (errCnt != '1)) errCnt <= errCnt + 1'b1;
      irqOut <= |(pendingQ & ~maskQ);
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_PEND: regRdData = pendingQ;
      ADDR_MASK: regRdData = maskQ;
      ADDR_ERR:  regRdData = {{PAD_W{1'b0}}, errCnt};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/msi_level_bridge.sv
module msi_level_bridge
  import msi_bridge_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int IDX_W   = 6,
  parameter int ERR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  msgValid,
  input  logic [IDX_W-1:0]      msgVector,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_VEC-1:0]    regWrData,
  output logic [NUM_VEC-1:0]    regRdData,
  output logic                  irqOut
);
  ctrlStrobes_t       strb;
  logic [NUM_VEC-1:0] pendingQ;
  logic [NUM_VEC-1:0] maskQ;
  logic [ERR_W-1:0]   errCnt;

  msi_bridge_ctrl #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_ctrl (
    .msgValid (msgValid),
    .msgVector(msgVector),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .strb     (strb)
  );

  msi_bridge_dp #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .ERR_W(ERR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .msgVector(msgVector),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .pendingQ (pendingQ),
    .maskQ    (maskQ),
    .errCnt   (errCnt),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/msi_bridge_chk.sv
module msi_bridge_chk
  import msi_bridge_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int IDX_W   = 6,
  parameter int ERR_W   = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  msgValid,
  input logic [IDX_W-1:0]      msgVector,
  input logic                  regWrEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [NUM_VEC-1:0]    regWrData,
  input logic [NUM_VEC-1:0]    pendingQ,
  input logic [NUM_VEC-1:0]    maskQ,
  input logic [ERR_W-1:0]      errCnt,
  input logic                  irqOut
);
  logic okVec;
  logic ackNow;
  assign okVec  = msgValid && (int'(msgVector) < NUM_VEC);
  assign ackNow = regWrEn && (regAddr == ADDR_PEND);

  AST_MSG_SETS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    okVec |=> ((pendingQ >> $past(msgVector)) & NUM_VEC'(1)) != '0); // R1

  AST_LEVEL_REGISTERED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|(pendingQ & ~maskQ))); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackNow && !msgValid) |=> (pendingQ & $past(regWrData)) == '0); // R4

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    !ackNow |=> (pendingQ & $past(pendingQ)) == $past(pendingQ)); // R5

  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (okVec && ackNow) |=> ((pendingQ >> $past(msgVector)) & NUM_VEC'(1)) != '0); // R7

  AST_ERR_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !okVec && errCnt != '1) |=> errCnt == $past(errCnt) + 1'b1); // R8

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == '1) |=> errCnt == '1); // R8
endmodule

bind msi_level_bridge msi_bridge_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgVector(msgVector),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .pendingQ(pendingQ), .maskQ(maskQ), .errCnt(errCnt), .irqOut(irqOut)
);

// File: tb/tb_msi_level_bridge.sv
module tb_msi_level_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic [5:0]  msgVector = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  msi_level_bridge dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgVector(msgVector),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #2;
    d = regRdData;
  endtask

  task automatic send(input logic [5:0] v);
    @(negedge clk);
    msgValid = 1'b1; msgVector = v;
    @(negedge clk);
    msgValid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(2'd0, d); chk("R9 pending", d, 32'h0);
    rd(2'd1, d); chk("R9 mask", d, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R9 errcnt", d, 32'h0);
    chk("R9 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_masked_latch();
    logic [31:0] d;
    send(6'd5);
    rd(2'd0, d); chk("R1 R3 pending after msg", d, 32'h20);
    @(negedge clk);
    chk("R5 masked irq stays low", {31'b0, irqOut}, 32'h0);
    rd(2'd0, d); chk("R5 masked msg latched", d, 32'h20);
  endtask

  task automatic t_unmask();
    wr(2'd1, ~32'h20);
    chk("R2 irq one cycle later", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    chk("R6 unmask raises irq", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    send(6'd9);                 // vector 9 still masked
    wr(2'd0, 32'h0);            // zeros clear nothing
    rd(2'd0, d); chk("R4 zero write no effect", d, 32'h220);
    wr(2'd0, 32'h20);
    rd(2'd0, d); chk("R4 ack clears bit", d, 32'h200);
    @(negedge clk);
    chk("R4 irq low after ack", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    wr(2'd1, 32'h0);            // unmask all, vector 9 pending
    @(negedge clk);
    chk("R6 pending 9 raises irq", {31'b0, irqOut}, 32'h1);
    send(6'd3);
    wr(2'd0, 32'h200);
    @(negedge clk);
    chk("R4 irq held by other vector", {31'b0, irqOut}, 32'h1);
    rd(2'd0, d); chk("R3 remaining pending", d, 32'h8);
    wr(2'd1, 32'hFFFF_FFFF);    // mask with pending set
    @(negedge clk);
    chk("R2 masking drops level", {31'b0, irqOut}, 32'h0);
    wr(2'd1, 32'h0);
    @(negedge clk);
    chk("R6 unmask restores level", {31'b0, irqOut}, 32'h1);
    wr(2'd0, 32'h8);
    @(negedge clk);
    chk("R4 last ack drops irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    msgValid = 1'b1; msgVector = 6'd7;
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h80;
    @(negedge clk);
    msgValid = 1'b0; regWrEn = 1'b0; regWrData = '0;
    rd(2'd0, d); chk("R7 set wins over ack", d, 32'h80);
    @(negedge clk);
    chk("R7 irq for collided vector", {31'b0, irqOut}, 32'h1);
    wr(2'd0, 32'h80);
    rd(2'd0, d); chk("R4 clean ack", d, 32'h0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    send(6'd32);
    send(6'd63);
    rd(2'd0, d); chk("R8 no pending from bad index", d, 32'h0);
    rd(2'd2, d); chk("R8 error count", d, 32'd2);
    @(negedge clk);
    chk("R8 no irq from bad index", {31'b0, irqOut}, 32'h0);
    for (int i = 0; i < 300; i++) send(6'd40);
    rd(2'd2, d); chk("R8 error count saturates", d, 32'd255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_masked_latch();
    t_unmask();
    t_ack();
    t_multi();
    t_collide();
    t_range();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule